// File: doc/BRIEF.md
# Scratchpad-to-Memory Store DMA

This engine copies 32-bit words out of a 64-row by 16-column scratchpad into external system memory. Software first writes a 32-bit setup word, which names a starting row and column, an orientation, a count of units and a number of words per unit. Software then writes a byte destination address. That address write starts the transfer. The engine walks the scratchpad one word per accepted memory write and places the words at consecutive word addresses.

A unit is read either down a column (vertical) or along a row (horizontal). In vertical mode, each new unit starts one column to the right in the same 16-row band. When the column steps past 15, it wraps to 0 and the band moves down 16 rows. In horizontal mode, each new unit starts one row lower in the same column. The engine presents every write on a request/acknowledge port and holds it until it is accepted. While a transfer runs, `busy` is high, and a pending status read is stalled through `wait_stall`.

Top module: `sp_dma_store`

## Requirements
- R1: Setup bits 31:30 hold the kind, which must be binary 10. Bit 15 is the packing flag and must be 0. Bits 2:0 hold the element width and must be 000. When the setup holds such a value, an address write while idle raises `busy` on the next cycle. The first write then goes to the written address with bits 1:0 cleared.
- R2: When the kind, the packing flag or the width holds any other value, an address write is ignored: `busy` and `mem_req` stay low.
- R3: Bit 14 = 0 selects vertical mode. The row starts from bits 12:7 (bit 13 is ignored) and the column from bits 6:3. Each unit moves the number of words given in bits 22:16. In vertical mode the row steps by 1 modulo 64 within a unit, and the column stays fixed.
- R4: In vertical mode, the next unit starts one column to the right at the same row as the previous unit's start. From column 15, it starts instead at column 0 and 16 rows lower, modulo 64.
- R5: Bit 14 = 1 selects horizontal mode. Within a unit the column steps by 1. Past column 15, the column wraps to 0 and the row steps by 1, modulo 64. The next unit starts one row lower, modulo 64, at the original column.
- R6: The unit count is in bits 29:23. A unit-count or words-per-unit field of 0 means 128.
- R7: Each write carries the scratchpad word at the row and column presented in the same cycle. Request, address and position hold still until `mem_ack`. Each accepted write advances the address by 4.
- R8: Exactly units × depth writes are made. `busy` falls on the cycle after the last write is acknowledged and at no other time.
- R9: `wait_stall` is high exactly when `wait_rd` is high and a transfer is in progress.
- R10: An address write while busy is ignored. A setup write while busy does not change the running transfer and governs the next one. An address write in the same cycle as a setup write uses the earlier setup.
- R11: After reset, `busy` and `mem_req` are low and the setup holds 0, so an address write without a prior setup is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_setup_we | input | 1 | Setup word write strobe |
| cfg_setup_data | input | 32 | Setup word |
| cfg_addr_we | input | 1 | Destination address write strobe; starts a transfer |
| cfg_addr_data | input | ADDR_W | Byte destination address |
| busy | output | 1 | Transfer in progress |
| wait_rd | input | 1 | Status read that must wait for completion |
| wait_stall | output | 1 | Stalls the pending status read |
| sp_rd_row | output | 6 | Scratchpad read row |
| sp_rd_col | output | 4 | Scratchpad read column |
| sp_rd_data | input | DATA_W | Scratchpad word at the presented position |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory write accepted |

## Verification
The scratchpad is filled with values that are unique per row and column. Every written word therefore identifies the position it was read from, and any slip in walk order shows up as wrong data.

The following transfers are applied:
- A four-unit vertical transfer starting in column 15. It separates a column wrap that moves the band down from one that does not.
- A horizontal transfer starting in the last row. It shows the row wrap within a unit and between units.
- Two transfers with a zero field, of 128 one-word units and of one 128-word unit. They tell the 128 encoding apart from a zero-length transfer.
- Runs with always-on and irregular acknowledges. These separate a correct hold from an early advance.
- Malformed setups and address or setup writes during a transfer. These show which writes are rejected or deferred.

// File: rtl/spdma_pkg.sv
package spdma_pkg;

    localparam int SP_ROWS  = 64;
    localparam int SP_COLS  = 16;
    localparam int VBAND    = 16;
    localparam int ROW_W    = $clog2(SP_ROWS);
    localparam int COL_W    = $clog2(SP_COLS);
    localparam int FIELD_W  = 7;
    localparam int CNT_W    = FIELD_W + 1;

    localparam logic [1:0] KIND_STORE = 2'b10;
    localparam logic [2:0] WIDTH_32   = 3'b000;

    // 32-bit setup word, most significant field first
    typedef struct packed {
        logic [1:0]         kind;
        logic [FIELD_W-1:0] units;
        logic [FIELD_W-1:0] depth;
        logic               laned;
        logic               horiz;
        logic [6:0]         row;
        logic [3:0]         col;
        logic [2:0]         width;
    } setup_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } sp_pos_t;

    typedef enum logic {ST_IDLE, ST_RUN} state_t;

    function automatic logic setup_ok(setup_t s);
        return (s.kind == KIND_STORE) && !s.laned && (s.width == WIDTH_32);
    endfunction

    function automatic logic [CNT_W-1:0] field_count(logic [FIELD_W-1:0] f);
        return (f == '0) ? CNT_W'(1 << FIELD_W) : {1'b0, f};
    endfunction

    // next word inside a unit
    function automatic sp_pos_t next_in_unit(sp_pos_t p, logic horiz);
        sp_pos_t n;
        n = p;
        if (horiz) begin
            if (p.col == COL_W'(SP_COLS - 1)) begin
                n.col = '0;
                n.row = p.row + 1'b1;
            end else begin
                n.col = p.col + 1'b1;
            end
        end else begin
            n.row = p.row + 1'b1;
        end
        return n;
    endfunction

    // start of the following unit, from the start of the current one
    function automatic sp_pos_t next_unit(sp_pos_t s, logic horiz);
        sp_pos_t n;
        n = s;
        if (horiz) begin
            n.row = s.row + 1'b1;
        end else if (s.col == COL_W'(SP_COLS - 1)) begin
            n.col = '0;
            n.row = s.row + ROW_W'(VBAND);
        end else begin
            n.col = s.col + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/spdma_setup_reg.sv
module spdma_setup_reg
    import spdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output setup_t      setup_q,
    output logic        valid
);

    always_ff @(posedge clk) begin
        if (rst)     setup_q <= '0;
        else if (we) setup_q <= setup_t'(wdata);
    end

    assign valid = setup_ok(setup_q);

endmodule

// File: rtl/spdma_walker.sv
module spdma_walker
    import spdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  sp_pos_t            start_pos,
    input  logic [FIELD_W-1:0] units_f,
    input  logic [FIELD_W-1:0] depth_f,
    input  logic               horiz,
    output sp_pos_t            pos,
    output logic               last
);

    sp_pos_t          unit_q, pos_q;
    logic [CNT_W-1:0] words_left, units_left, depth_q;
    logic             horiz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_q     <= '0;
            pos_q      <= '0;
            words_left <= '0;
            units_left <= '0;
            depth_q    <= '0;
            horiz_q    <= 1'b0;
        end else if (load) begin
            unit_q     <= start_pos;
            pos_q      <= start_pos;
            words_left <= field_count(depth_f);
            units_left <= field_count(units_f);
            depth_q    <= field_count(depth_f);
            horiz_q    <= horiz;
        end else if (step) begin
            if (words_left != CNT_W'(1)) begin
                pos_q      <= next_in_unit(pos_q, horiz_q);
                words_left <= words_left - 1'b1;
            end else if (units_left != CNT_W'(1)) begin
                unit_q     <= next_unit(unit_q, horiz_q);
                pos_q      <= next_unit(unit_q, horiz_q);
                words_left <= depth_q;
                units_left <= units_left - 1'b1;
            end
        end
    end

    assign pos  = pos_q;
    assign last = (words_left == CNT_W'(1)) && (units_left == CNT_W'(1));

endmodule

// File: rtl/spdma_addr_ctr.sv
module spdma_addr_ctr #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);

    localparam int BYTES = DATA_W / 8;

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= base;
        else if (step) addr <= addr + ADDR_W'(BYTES);
    end

endmodule

// File: rtl/sp_dma_store.sv
module sp_dma_store
    import spdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_setup_we,
    input  logic [31:0]       cfg_setup_data,
    input  logic              cfg_addr_we,
    input  logic [ADDR_W-1:0] cfg_addr_data,
    output logic              busy,
    input  logic              wait_rd,
    output logic              wait_stall,
    output logic [5:0]        sp_rd_row,
    output logic [3:0]        sp_rd_col,
    input  logic [DATA_W-1:0] sp_rd_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack
);

    localparam int ALIGN_W = $clog2(DATA_W / 8);

    setup_t  setup_q;
    logic    setup_valid;
    state_t  state_q;
    logic    start, fire, last;
    sp_pos_t pos, start_pos;
    logic    unused_sink;

    spdma_setup_reg i_setup (
        .clk(clk), .rst(rst), .we(cfg_setup_we), .wdata(cfg_setup_data),
        .setup_q(setup_q), .valid(setup_valid)
    );

    assign start     = cfg_addr_we && (state_q == ST_IDLE) && setup_valid;
    assign fire      = mem_req && mem_ack;
    assign start_pos = '{row: setup_q.row[ROW_W-1:0], col: setup_q.col};

    spdma_walker i_walker (
        .clk(clk), .rst(rst), .load(start), .step(fire),
        .start_pos(start_pos), .units_f(setup_q.units), .depth_f(setup_q.depth),
        .horiz(setup_q.horiz), .pos(pos), .last(last)
    );

    spdma_addr_ctr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_addr (
        .clk(clk), .rst(rst), .load(start), .step(fire),
        .base({cfg_addr_data[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}}),
        .addr(mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start)        state_q <= ST_RUN;
                ST_RUN:  if (fire && last) state_q <= ST_IDLE;
                default:                   state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == ST_RUN);
    assign mem_req    = busy;
    assign mem_wdata  = sp_rd_data;
    assign sp_rd_row  = pos.row;
    assign sp_rd_col  = pos.col;
    assign wait_stall = wait_rd && busy;

    assign unused_sink = ^{cfg_addr_data[ALIGN_W-1:0], setup_q.row[6]};

endmodule

// File: rtl/spdma_store_chk.sv
module spdma_store_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_addr_we,
    input logic              setup_valid,
    input logic              busy,
    input logic              wait_stall,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [5:0]        sp_rd_row,
    input logic [3:0]        sp_rd_col
);

    p_start_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_addr_we && !busy && setup_valid |=> busy);

    p_reject_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_addr_we && !busy && !setup_valid |=> !busy);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)
                                && $stable(sp_rd_row) && $stable(sp_rd_col));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !busy || (mem_addr == $past(mem_addr) + ADDR_W'(4)));

    p_end_on_ack_r8: assert property (@(posedge clk) disable iff (rst)
        busy && !(mem_req && mem_ack) |=> busy);

    p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wait_stall);

    p_reset_state_r11: assert property (@(posedge clk)
        rst |=> !busy && !mem_req);

endmodule

bind sp_dma_store spdma_store_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .cfg_addr_we(cfg_addr_we), .setup_valid(setup_valid),
    .busy(busy), .wait_stall(wait_stall), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .sp_rd_row(sp_rd_row), .sp_rd_col(sp_rd_col)
);

// File: tb/test_sp_dma_store.sv
module test_sp_dma_store;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_setup_we = 1'b0;
    logic [31:0] cfg_setup_data = '0;
    logic        cfg_addr_we = 1'b0;
    logic [31:0] cfg_addr_data = '0;
    logic        busy, wait_stall, mem_req;
    logic        wait_rd = 1'b0;
    logic        mem_ack = 1'b0;
    logic [5:0]  sp_rd_row;
    logic [3:0]  sp_rd_col;
    logic [31:0] sp_rd_data, mem_addr, mem_wdata;

    logic [31:0] spm [64][16];

    always #10 clk = ~clk;

    assign sp_rd_data = spm[sp_rd_row][sp_rd_col];

    sp_dma_store i_sp_dma_store (
        .clk(clk), .rst(rst),
        .cfg_setup_we(cfg_setup_we), .cfg_setup_data(cfg_setup_data),
        .cfg_addr_we(cfg_addr_we), .cfg_addr_data(cfg_addr_data),
        .busy(busy), .wait_rd(wait_rd), .wait_stall(wait_stall),
        .sp_rd_row(sp_rd_row), .sp_rd_col(sp_rd_col), .sp_rd_data(sp_rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack)
    );

    // reference model state
    bit          exp_busy = 0;
    logic [31:0] m_setup = '0;
    logic [31:0] qa[$];
    logic [31:0] qd[$];
    int          checks = 0;
    int          fails = 0;
    string       tag = "R11";
    int          ack_mode = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    function automatic bit desc_ok(logic [31:0] s);
        return (s[31:30] == 2'b10) && !s[15] && (s[2:0] == 3'b000);
    endfunction

    function automatic logic [31:0] mk(int units, int depth, bit horiz, int row, int col);
        return {2'b10, 7'(units), 7'(depth), 1'b0, horiz, 7'(row), 4'(col), 3'b000};
    endfunction

    task automatic build(logic [31:0] s, logic [31:0] base);
        int nu = (s[29:23] == 0) ? 128 : int'(s[29:23]);
        int nd = (s[22:16] == 0) ? 128 : int'(s[22:16]);
        int y0 = int'(s[12:7]);
        int x0 = int'(s[6:3]);
        int n  = 0;
        for (int u = 0; u < nu; u++) begin
            for (int k = 0; k < nd; k++) begin
                int y, x;
                if (s[14]) begin
                    int lin = (y0 + u) * 16 + x0 + k;
                    y = (lin / 16) % 64;
                    x = lin % 16;
                end else begin
                    int c = x0 + u;
                    x = c % 16;
                    y = (y0 + 16 * (c / 16) + k) % 64;
                end
                qa.push_back((base & 32'hFFFF_FFFC) + 32'(4 * n));
                qd.push_back(spm[y][x]);
                n++;
            end
        end
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: compare at negedge, drive inputs, advance the model over the coming edge
    task automatic cyc(bit swe, logic [31:0] sd, bit awe, logic [31:0] ad);
        bit was_busy;
        @(negedge clk);
        check("busy", 32'(busy), 32'(exp_busy));
        check("mem_req", 32'(mem_req), 32'(exp_busy));
        check("wait_stall", 32'(wait_stall), 32'(wait_rd && exp_busy));
        if (exp_busy) begin
            check("mem_addr", mem_addr, qa[0]);
            check("mem_wdata", mem_wdata, qd[0]);
        end
        if (ack_mode == 0) mem_ack = 1'b1;
        else begin
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            mem_ack = lfsr[16] | lfsr[21];
        end
        cfg_setup_we   = swe;
        cfg_setup_data = sd;
        cfg_addr_we    = awe;
        cfg_addr_data  = ad;
        was_busy = exp_busy;
        if (exp_busy && mem_ack) begin
            void'(qa.pop_front());
            void'(qd.pop_front());
            if (qa.size() == 0) exp_busy = 0;
        end
        if (awe && !was_busy && desc_ok(m_setup)) begin
            build(m_setup, ad);
            exp_busy = 1;
        end
        if (swe) m_setup = sd;
    endtask

    task automatic run_done();
        int guard = 0;
        while (exp_busy && guard < 40000) begin
            cyc(0, '0, 0, '0);
            guard++;
        end
        cyc(0, '0, 0, '0);
        cyc(0, '0, 0, '0);
    endtask

    task automatic start(logic [31:0] s, logic [31:0] a);
        cyc(1, s, 0, '0);
        cyc(0, '0, 1, a);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired actual busy expected idle");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 64; r++)
            for (int c = 0; c < 16; c++)
                spm[r][c] = 32'hC3000000 ^ 32'(r << 12) ^ 32'(c << 4) ^ 32'(r * 16 + c);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state; address write with the reset setup is refused
        tag = "R11";
        cyc(0, '0, 0, '0);
        cyc(0, '0, 1, 32'h0000_1000);
        cyc(0, '0, 0, '0);
        cyc(0, '0, 0, '0);

        // R1/R3/R4/R8: four vertical units from row 0, column 15, unaligned base
        tag = "R1/R3/R4/R8";
        start(mk(4, 16, 0, 0, 15), 32'h2000_0003);
        run_done();

        // R7: same walk under irregular acknowledges
        tag = "R7";
        ack_mode = 1;
        cyc(0, '0, 1, 32'h3000_0040);
        run_done();

        // R5: horizontal, starting in the last row, wraps in and between units
        tag = "R5";
        start(mk(3, 20, 1, 63, 10), 32'h4000_0100);
        run_done();

        // R2: malformed setups are refused
        tag = "R2";
        ack_mode = 0;
        start(mk(1, 4, 0, 0, 0) ^ 32'hC000_0000, 32'h5000_0000);
        cyc(0, '0, 0, '0);
        start(mk(1, 4, 0, 0, 0) | 32'h0000_8000, 32'h5000_0000);
        cyc(0, '0, 0, '0);
        start(mk(1, 4, 0, 0, 0) | 32'h0000_0001, 32'h5000_0000);
        cyc(0, '0, 0, '0);

        // R6: zero unit count and zero depth both mean 128
        tag = "R6";
        start(mk(0, 1, 0, 40, 14), 32'h6000_0000);
        run_done();
        ack_mode = 1;
        start(mk(1, 0, 1, 5, 3), 32'h6100_0000);
        run_done();

        // R9: status read stalled only while busy
        tag = "R9";
        wait_rd = 1'b1;
        cyc(0, '0, 0, '0);
        start(mk(2, 5, 0, 60, 7) | 32'h0000_2000, 32'h7000_0000);
        run_done();
        wait_rd = 1'b0;

        // R10: writes during a transfer
        tag = "R10";
        start(mk(2, 8, 0, 8, 2), 32'h8000_0000);
        cyc(0, '0, 0, '0);
        cyc(1, mk(2, 3, 1, 33, 9), 1, 32'h8800_0000);
        run_done();
        cyc(0, '0, 1, 32'h9000_0000);
        run_done();
        cyc(1, mk(1, 2, 0, 1, 1), 1, 32'h9100_0000);
        run_done();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule